// File: doc/BRIEF.md
# Program Sequencer with Return Stack

This block holds the program counter of a small 4-bit controller and decides where the next opcode byte is fetched from. The counter has two fields: a page number and an offset within the page. An external fetch stage presents one opcode byte per cycle with a valid strobe, and the block consumes it at the current address. Plain bytes advance the offset. Jump, call and return opcodes reload the counter. A parameterised return-address stack holds the addresses that calls save.

Three opcodes return from a call: a plain return, a return that also skips the next instruction, and a return from interrupt that sets the interrupt master enable. Other units can ask for the next instruction to be skipped through a single-cycle request input. A skipped instruction uses one byte slot per byte of its own length. It changes nothing but the offset.

Top module: `program_sequencer`

## Requirements
- R1: After reset the page and offset are both 0, the interrupt master enable is 0 and both stack error flags are 0.
- R2: A consumed byte that does not change the flow increments the offset by one, modulo 64, and leaves the page unchanged. In a cycle with `opValid` low the address does not change.
- R3: A byte in the range 0x80..0xBF loads its low 6 bits into the offset and keeps the page.
- R4: A first byte in 0xE0..0xE7 followed by a second byte jumps to the 11-bit target {first[2:0], second}. Target bits [10:6] go to the page and bits [5:0] go to the offset.
- R5: A first byte in 0xF0..0xF7 followed by a second byte jumps like R4. It also pushes the address that follows the second byte.
- R6: A byte in 0xC0..0xDF pushes the address that follows it. It then loads page 1 and the offset {0, byte[4:0]}.
- R7: Byte 0x7D pops the top stack entry into the page and offset.
- R8: Byte 0x7E pops like R7 and marks the next instruction to be skipped.
- R9: A skipped instruction only advances the offset. It does not jump, push, pop or set the interrupt master enable.
- R10: A skipped instruction whose first byte is in 0xE0..0xE7 or 0xF0..0xF7 consumes two byte slots. Any other skipped instruction consumes one.
- R11: Byte 0x7F pops like R7 and sets the interrupt master enable to 1. The enable stays 1 until reset.
- R12: A pop on an empty stack sets a sticky underflow flag and loads address 0.
- R13: A push on a full stack sets a sticky overflow flag and stores nothing. The jump still happens, and the entries already stored stay unchanged.
- R14: When `skipReq` is high in a cycle, the next instruction whose first byte is consumed in a later cycle is skipped. An instruction whose first byte is consumed in that same cycle executes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | `opByte` is consumed this cycle |
| opByte | input | 8 | Opcode byte fetched at the current address |
| skipReq | input | 1 | Request from another unit to skip the next instruction |
| pcPage | output | PAGE_W | Page field of the fetch address |
| pcOffset | output | 6 | Offset field of the fetch address |
| intMasterEn | output | 1 | Interrupt master enable |
| stackOverflow | output | 1 | Sticky flag: a push found the stack full |
| stackUnderflow | output | 1 | Sticky flag: a pop found the stack empty |

## Verification
The bench builds the block with the default values: a 6-bit page, a four-entry stack and page 1 for short calls. Four entries let five nested short calls reach the overflow case, and the pops that follow show that a dropped push leaves the stored entries intact. Further pops then reach the underflow case. Long targets are chosen so that the page field receives non-zero upper bits. Both kinds of skip are covered: the skip after a return and the skip requested from outside. The skipped instructions include a two-byte instruction, a call and an interrupt return, so that the bench can confirm that none of them takes effect.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OFF_W  = 6;
  localparam int LONG_W = 11;

  typedef enum logic [1:0] {ST_FIRST, ST_SECOND, ST_SKIP2} seqState_e;

  typedef struct packed {
    logic              incPc;
    logic              loadPl;
    logic              loadLong;
    logic              loadShort;
    logic              push;
    logic              pop;
    logic              setIme;
    logic [LONG_W-1:0] target;
  } seqStrobe_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [7:0] opByte,
  input  logic       skipReq,
  output seqStrobe_t strb
);
  seqState_e state, nextState;
  logic [2:0] hiBits;
  logic       isCall;
  logic       skipPending;
  logic       setSkip;
  logic       consumeFirst;
  logic       isTwoByte;

  // first bytes 0xE0..0xE7 and 0xF0..0xF7 start two-byte instructions
  assign isTwoByte = (opByte[7:5] == 3'b111) && !opByte[3];

  always_comb begin
    strb         = '0;
    nextState    = state;
    setSkip      = 1'b0;
    consumeFirst = 1'b0;
    if (opValid) begin
      unique case (state)
        ST_FIRST: begin
          consumeFirst = 1'b1;
          if (skipPending) begin
            strb.incPc = 1'b1;
            if (isTwoByte) nextState = ST_SKIP2;
          end else if (opByte[7:6] == 2'b10) begin
            strb.loadPl = 1'b1;
            strb.target = {5'b0, opByte[5:0]};
          end else if (opByte[7:5] == 3'b110) begin
            strb.push      = 1'b1;
            strb.loadShort = 1'b1;
            strb.target    = {6'b0, opByte[4:0]};
          end else if (isTwoByte) begin
            strb.incPc = 1'b1;
            nextState  = ST_SECOND;
          end else if (opByte == 8'h7D) begin
            strb.pop = 1'b1;
          end else if (opByte == 8'h7E) begin
            strb.pop = 1'b1;
            setSkip  = 1'b1;
          end else if (opByte == 8'h7F) begin
            strb.pop    = 1'b1;
            strb.setIme = 1'b1;
          end else begin
            strb.incPc = 1'b1;
          end
        end
        ST_SECOND: begin
          strb.loadLong = 1'b1;
          strb.push     = isCall;
          strb.target   = {hiBits, opByte};
          nextState     = ST_FIRST;
        end
        default: begin
          strb.incPc = 1'b1;
          nextState  = ST_FIRST;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_FIRST;
      hiBits      <= '0;
      isCall      <= 1'b0;
      skipPending <= 1'b0;
    end else begin
      state <= nextState;
      if (consumeFirst) begin
        hiBits <= opByte[2:0];
        isCall <= opByte[4];
      end
      skipPending <= (skipPending & ~consumeFirst) | skipReq | setSkip;
    end
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int PAGE_W      = 6,
  parameter int STACK_DEPTH = 4,
  parameter int SHORT_PAGE  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  output logic [PAGE_W-1:0] pcPage,
  output logic [OFF_W-1:0]  pcOffset,
  output logic              intMasterEn,
  output logic              stackOverflow,
  output logic              stackUnderflow
);
  localparam int SP_W    = $clog2(STACK_DEPTH + 1);
  localparam int ENTRY_W = PAGE_W + OFF_W;

  logic [ENTRY_W-1:0] stackMem [STACK_DEPTH];
  logic [SP_W-1:0]    sp;
  logic [ENTRY_W-1:0] topEntry;
  logic [ENTRY_W-1:0] retAddr;
  logic               full, empty;

  assign full    = (sp == SP_W'(STACK_DEPTH));
  assign empty   = (sp == '0);
  assign retAddr = {pcPage, pcOffset + OFF_W'(1)};

  always_comb begin
    topEntry = '0;
    for (int i = 0; i < STACK_DEPTH; i++)
      if (sp == SP_W'(i + 1)) topEntry = stackMem[i];
  end

  for (genvar g = 0; g < STACK_DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) stackMem[g] <= '0;
      else if (strb.push && sp == SP_W'(g)) stackMem[g] <= retAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp             <= '0;
      pcPage         <= '0;
      pcOffset       <= '0;
      intMasterEn    <= 1'b0;
      stackOverflow  <= 1'b0;
      stackUnderflow <= 1'b0;
    end else begin
      if (strb.push) begin
        if (full) stackOverflow <= 1'b1;
        else      sp <= sp + SP_W'(1);
      end
      if (strb.pop) begin
        if (empty) stackUnderflow <= 1'b1;
        else       sp <= sp - SP_W'(1);
        {pcPage, pcOffset} <= empty ? '0 : topEntry;
      end else if (strb.loadLong) begin
        pcPage   <= PAGE_W'(strb.target[LONG_W-1:OFF_W]);
        pcOffset <= strb.target[OFF_W-1:0];
      end else if (strb.loadShort) begin
        pcPage   <= PAGE_W'(SHORT_PAGE);
        pcOffset <= strb.target[OFF_W-1:0];
      end else if (strb.loadPl) begin
        pcOffset <= strb.target[OFF_W-1:0];
      end else if (strb.incPc) begin
        pcOffset <= pcOffset + OFF_W'(1);
      end
      if (strb.setIme) intMasterEn <= 1'b1;
    end
  end
endmodule

// File: rtl/program_sequencer.sv
module program_sequencer
  import seq_pkg::*;
#(
  parameter int PAGE_W      = 6,
  parameter int STACK_DEPTH = 4,
  parameter int SHORT_PAGE  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [7:0]        opByte,
  input  logic              skipReq,
  output logic [PAGE_W-1:0] pcPage,
  output logic [5:0]        pcOffset,
  output logic              intMasterEn,
  output logic              stackOverflow,
  output logic              stackUnderflow
);
  seqStrobe_t strb;

  seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opByte(opByte),
    .skipReq(skipReq), .strb(strb)
  );

  seq_datapath #(
    .PAGE_W(PAGE_W), .STACK_DEPTH(STACK_DEPTH), .SHORT_PAGE(SHORT_PAGE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pcPage(pcPage),
    .pcOffset(pcOffset), .intMasterEn(intMasterEn),
    .stackOverflow(stackOverflow), .stackUnderflow(stackUnderflow)
  );
endmodule

// File: rtl/seq_checker.sv
module seq_checker
  import seq_pkg::*;
#(
  parameter int PAGE_W     = 6,
  parameter int SHORT_PAGE = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input seqStrobe_t        strb,
  input logic [PAGE_W-1:0] pcPage,
  input logic [5:0]        pcOffset,
  input logic              intMasterEn,
  input logic              stackOverflow,
  input logic              stackUnderflow
);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(pcPage) && $stable(pcOffset)));

  assert_seq_inc_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.incPc |=> (pcOffset == 6'($past(pcOffset) + 1'b1)) && $stable(pcPage));

  assert_inpage_jump_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPl |=> $stable(pcPage));

  assert_short_page_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadShort |=> (pcPage == PAGE_W'(SHORT_PAGE)));

  assert_one_action_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.incPc, strb.loadPl, strb.loadLong, strb.loadShort, strb.pop}));

  assert_ime_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    intMasterEn |=> intMasterEn);

  assert_no_underflow_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    stackUnderflow |=> stackUnderflow);

  assert_no_overflow_clear_R13: assert property (@(posedge clk) disable iff (!rstN)
    stackOverflow |=> stackOverflow);
endmodule

bind program_sequencer seq_checker #(.PAGE_W(PAGE_W), .SHORT_PAGE(SHORT_PAGE)) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .strb(strb), .pcPage(pcPage),
  .pcOffset(pcOffset), .intMasterEn(intMasterEn),
  .stackOverflow(stackOverflow), .stackUnderflow(stackUnderflow)
);

// File: tb/program_sequencer_tb.sv
module program_sequencer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [7:0] opByte = 8'h00;
  logic       skipReq = 1'b0;
  logic [5:0] pcPage;
  logic [5:0] pcOffset;
  logic       intMasterEn, stackOverflow, stackUnderflow;

  int checks = 0;
  int failures = 0;
  logic eIme = 0, eOvf = 0, eUdf = 0;
  logic [14:0] expQ[$];
  string tagQ[$];
  logic sawValid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  program_sequencer u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opByte(opByte),
    .skipReq(skipReq), .pcPage(pcPage), .pcOffset(pcOffset),
    .intMasterEn(intMasterEn), .stackOverflow(stackOverflow),
    .stackUnderflow(stackUnderflow)
  );

  task automatic checkNow(input logic [14:0] exp, input string tag);
    logic [14:0] act;
    act = {pcPage, pcOffset, intMasterEn, stackOverflow, stackUnderflow};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual page=%h off=%h ime=%b ovf=%b udf=%b expected page=%h off=%h ime=%b ovf=%b udf=%b",
               tag, act[14:9], act[8:3], act[2], act[1], act[0],
               exp[14:9], exp[8:3], exp[2], exp[1], exp[0]);
    end
  endtask

  // driver: present one byte, queue the state expected after it is consumed
  task automatic send(input logic [7:0] b, input logic [5:0] pg,
                      input logic [5:0] off, input string tag, input logic withSkip = 1'b0);
    @(negedge clk);
    opValid = 1'b1;
    opByte  = b;
    skipReq = withSkip;
    expQ.push_back({pg, off, eIme, eOvf, eUdf});
    tagQ.push_back(tag);
  endtask

  task automatic requestSkip();
    @(negedge clk);
    opValid = 1'b0;
    skipReq = 1'b1;
    @(negedge clk);
    skipReq = 1'b0;
  endtask

  // monitor
  always @(posedge clk) sawValid <= opValid && rstN;

  always @(negedge clk) begin
    if (sawValid) begin
      if (expQ.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL scoreboard: actual unexpected byte expected none");
      end else begin
        checkNow(expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkNow(15'h0, "R1 reset");
    send(8'h00, 6'h00, 6'h01, "R2 increment");
    send(8'h85, 6'h00, 6'h05, "R3 in-page jump");
    send(8'hBF, 6'h00, 6'h3F, "R3 jump to last offset");
    send(8'h00, 6'h00, 6'h00, "R2 wrap within page");
    @(negedge clk); opValid = 1'b0;
    @(negedge clk);
    checkNow({6'h00, 6'h00, 3'b000}, "R2 idle hold");
    send(8'hE5, 6'h00, 6'h01, "R4 long jump first byte");
    send(8'h9A, 6'h16, 6'h1A, "R4 long jump target");
    send(8'hC7, 6'h01, 6'h07, "R6 short call");
    send(8'hF2, 6'h01, 6'h08, "R5 long call first byte");
    send(8'h41, 6'h09, 6'h01, "R5 long call target");
    send(8'h7D, 6'h01, 6'h09, "R7 R5 return past second byte");
    send(8'h7D, 6'h16, 6'h1B, "R7 R6 return after short call");
    send(8'hC3, 6'h01, 6'h03, "R6 short call");
    send(8'h7E, 6'h16, 6'h1C, "R8 return with skip");
    send(8'h85, 6'h16, 6'h1D, "R8 R9 jump skipped");
    send(8'h00, 6'h16, 6'h1E, "R8 normal after skip");
    requestSkip();
    send(8'hE1, 6'h16, 6'h1F, "R10 skip two-byte first");
    send(8'hFF, 6'h16, 6'h20, "R10 skip two-byte second");
    send(8'h81, 6'h16, 6'h01, "R10 next executes");
    requestSkip();
    send(8'hC5, 6'h16, 6'h02, "R9 call skipped");
    requestSkip();
    send(8'h7F, 6'h16, 6'h03, "R9 interrupt return skipped");
    send(8'h00, 6'h16, 6'h04, "R14 same-cycle byte executes", 1'b1);
    send(8'h86, 6'h16, 6'h05, "R14 following byte skipped");
    send(8'hC0, 6'h01, 6'h00, "R6 short call");
    eIme = 1'b1;
    send(8'h7F, 6'h16, 6'h06, "R11 interrupt return");
    eUdf = 1'b1;
    send(8'h7D, 6'h00, 6'h00, "R12 underflow");
    send(8'hC1, 6'h01, 6'h01, "R13 fill 1");
    send(8'hC2, 6'h01, 6'h02, "R13 fill 2");
    send(8'hC3, 6'h01, 6'h03, "R13 fill 3");
    send(8'hC4, 6'h01, 6'h04, "R13 fill 4");
    eOvf = 1'b1;
    send(8'hC5, 6'h01, 6'h05, "R13 overflow push");
    send(8'h7D, 6'h01, 6'h04, "R13 entry kept 4");
    send(8'h7D, 6'h01, 6'h03, "R13 entry kept 3");
    send(8'h7D, 6'h01, 6'h02, "R13 entry kept 2");
    send(8'h7D, 6'h00, 6'h01, "R13 entry kept 1");
    send(8'h7D, 6'h00, 6'h00, "R12 underflow again");
    @(negedge clk); opValid = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL scoreboard drain: actual %0d left expected 0", expQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule